// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects a bank of interrupt inputs and presents one active-low request line to a processor. Each input has its own control word that selects how it triggers and what priority it carries. The four trigger kinds are high level, low level, rising edge and falling edge. Software changes the enable state of inputs through write-one command words, and can force an input pending or clear its pending state by command.

A request is served in two steps. The processor reads the vector word, which returns the winning input number times four. That read is the acknowledge: the request line releases and the controller enters its service state. The line stays released until software writes the end-of-service word. The controller then looks at the pending inputs again and raises the request if any enabled input is still pending.

The register interface is a plain 32-bit bus with a write strobe and a read strobe. Read data is combinational from the address.

Top module: `intc_vectored`

## Requirements
- R1: After reset all inputs are disabled (enable word at 0x110 reads 0), every control word reads 0x40 (high level, priority 0) and `irqReqN` is 1.
- R2: Input n has a control word at byte offset n*4. Bits [7:6] select the trigger (0 low level, 1 high level, 2 falling edge, 3 rising edge) and bits [2:0] hold the priority. All other bits read as 0.
- R3: Writing to 0x114 enables each input whose data bit is 1. Writing to 0x118 disables each input whose data bit is 1. Zero bits leave their inputs unchanged. The enable state reads back at 0x110, where 1 means enabled.
- R4: An input in level mode is pending for exactly as long as its pin is at the active level: 1 for high level, 0 for low level.
- R5: An input in edge mode latches a pending bit on the selected transition. The bit stays set after the pin returns and is cleared when that input is acknowledged.
- R6: Among pending, enabled inputs the highest priority value wins. Equal priorities go to the lowest input number.
- R7: A read of 0x10C while requesting returns the winner number times 4 and acknowledges. `irqReqN` then stays 1 until end-of-service, and repeated reads of 0x10C return the same value.
- R8: Any write to 0x124 while in service ends the service. If an enabled input is still pending, `irqReqN` goes to 0 again.
- R9: Writing 1 bits to 0x11C forces those inputs pending. Writing 1 bits to 0x120 clears their latched pending state. An acknowledge also clears a forced bit.
- R10: 0x100 reads the raw pin levels, 0x104 reads the pending vector before enables are applied, and 0x108 reads pending AND enabled.
- R11: A pending but disabled input never drives `irqReqN` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (a read of 0x10C acknowledges) |
| regAddr | input | ADDR_W | Byte address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from address |
| irqIn | input | NUM_SRC | Interrupt input pins |
| irqReqN | output | 1 | Active-low interrupt request |

## Verification
The bench walks each input through a full acknowledge and end-of-service cycle. A wrong vector scale or a wrong index would show up as a bad value read at 0x10C. It also checks that the request line stays released while an input is still asserted during service; a controller that re-raised early would invite nested handling. Priority sweeps on arithmetic input patterns include ties, which catch an arbiter that favours the highest index or compares with >= instead of >. Edge tests confirm that a captured edge survives the pin falling back and is cleared by the acknowledge. Otherwise the handler would be entered twice, or would never see the event.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int OFF_RAW    = 'h100;
  localparam int OFF_PEND   = 'h104;
  localparam int OFF_STAT   = 'h108;
  localparam int OFF_VEC    = 'h10C;
  localparam int OFF_ENABLE = 'h110;
  localparam int OFF_UNMASK = 'h114;
  localparam int OFF_MASK   = 'h118;
  localparam int OFF_FORCE  = 'h11C;
  localparam int OFF_UNFORCE= 'h120;
  localparam int OFF_EOS    = 'h124;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_RISE = 2'd3
  } trig_e;

  typedef struct packed {
    logic ackTake;
    logic inService;
  } ctlStrobe_t;

endpackage

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [31:0]         regWrData,
  input  logic [NUM_SRC-1:0]  irqIn,
  input  ctlStrobe_t          strobe,
  output logic                anyCand,
  output logic [31:0]         rdData
);

  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int IDX_W = ADDR_W - 2;

  trig_e               trigArr [NUM_SRC];
  logic [PRIO_W-1:0]   prioArr [NUM_SRC];
  logic [NUM_SRC-1:0]  enBits, latchBits, prevIn;
  logic [NUM_SRC-1:0]  levelAct, edgeHit, pendVec, candVec;
  logic [NUM_SRC-1:0]  unmaskBits, maskBits, forceBits, unforceBits, ackClr;
  logic [SRC_W-1:0]    winner, curSrc;
  logic [PRIO_W-1:0]   bestPrio;
  logic [IDX_W-1:0]    ctrlIdx;
  logic [SRC_W-1:0]    srcSel;
  logic                ctrlHit;

  assign ctrlIdx = regAddr[ADDR_W-1:2];
  assign srcSel  = ctrlIdx[SRC_W-1:0];
  assign ctrlHit = (regAddr < ADDR_W'(NUM_SRC * 4)) && (regAddr[1:0] == 2'b00);

  assign unmaskBits  = (regWrEn && regAddr == ADDR_W'(OFF_UNMASK))  ? regWrData[NUM_SRC-1:0] : '0;
  assign maskBits    = (regWrEn && regAddr == ADDR_W'(OFF_MASK))    ? regWrData[NUM_SRC-1:0] : '0;
  assign forceBits   = (regWrEn && regAddr == ADDR_W'(OFF_FORCE))   ? regWrData[NUM_SRC-1:0] : '0;
  assign unforceBits = (regWrEn && regAddr == ADDR_W'(OFF_UNFORCE)) ? regWrData[NUM_SRC-1:0] : '0;
  assign ackClr      = strobe.ackTake ? (NUM_SRC'(1) << winner) : '0;

  // Per-input control word and trigger decode
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        trigArr[g] <= TRIG_HIGH;
        prioArr[g] <= '0;
      end else if (regWrEn && ctrlHit && ctrlIdx == IDX_W'(g)) begin
        trigArr[g] <= trig_e'(regWrData[7:6]);
        prioArr[g] <= regWrData[PRIO_W-1:0];
      end
    end

    always_comb begin
      levelAct[g] = 1'b0;
      edgeHit[g]  = 1'b0;
      unique case (trigArr[g])
        TRIG_LOW:  levelAct[g] = ~irqIn[g];
        TRIG_HIGH: levelAct[g] =  irqIn[g];
        TRIG_FALL: edgeHit[g]  = ~irqIn[g] &  prevIn[g];
        TRIG_RISE: edgeHit[g]  =  irqIn[g] & ~prevIn[g];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBits    <= '0;
      latchBits <= '0;
      prevIn    <= '0;
      curSrc    <= '0;
    end else begin
      enBits    <= (enBits | unmaskBits) & ~maskBits;
      latchBits <= ((latchBits & ~ackClr) | edgeHit | forceBits) & ~unforceBits;
      prevIn    <= irqIn;
      if (strobe.ackTake) curSrc <= winner;
    end
  end

  assign pendVec = latchBits | levelAct;
  assign candVec = pendVec & enBits;

  // Arbiter: strict greater-than keeps the lowest index on ties
  always_comb begin
    anyCand  = 1'b0;
    bestPrio = '0;
    winner   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (candVec[i] && (!anyCand || prioArr[i] > bestPrio)) begin
        anyCand  = 1'b1;
        bestPrio = prioArr[i];
        winner   = SRC_W'(i);
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (ctrlHit) begin
      rdData[7:6]        = trigArr[srcSel];
      rdData[PRIO_W-1:0] = prioArr[srcSel];
    end else begin
      case (int'(regAddr))
        OFF_RAW:    rdData = 32'(irqIn);
        OFF_PEND:   rdData = 32'(pendVec);
        OFF_STAT:   rdData = 32'(candVec);
        OFF_ENABLE: rdData = 32'(enBits);
        OFF_VEC: begin
          if (strobe.inService) rdData = 32'({curSrc, 2'b00});
          else if (anyCand)     rdData = 32'({winner, 2'b00});
        end
        default: rdData = '0;
      endcase
    end
  end

  p_unmask_cmd_r3: assert property (@(posedge clk) disable iff (!rstN)
    (unmaskBits != '0) |=> ((enBits & $past(unmaskBits)) == $past(unmaskBits)));

  p_mask_cmd_r3: assert property (@(posedge clk) disable iff (!rstN)
    (maskBits != '0) |=> ((enBits & $past(maskBits)) == '0));

  p_winner_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    anyCand |-> candVec[winner]);

  p_force_pends_r9: assert property (@(posedge clk) disable iff (!rstN)
    (forceBits != '0 && unforceBits == '0) |=> ((pendVec & $past(forceBits)) == $past(forceBits)));

endmodule

// File: rtl/intc_control.sv
module intc_control
  import intc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              anyCand,
  output ctlStrobe_t        strobe,
  output logic              irqReqN
);

  typedef enum logic {ST_IDLE, ST_SERVE} state_e;
  state_e state;

  logic ackRead, eosWr;
  assign ackRead = regRdEn && regAddr == ADDR_W'(OFF_VEC);
  assign eosWr   = regWrEn && regAddr == ADDR_W'(OFF_EOS);

  assign strobe.ackTake   = (state == ST_IDLE) && ackRead && anyCand;
  assign strobe.inService = (state == ST_SERVE);
  assign irqReqN          = !((state == ST_IDLE) && anyCand);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else begin
      unique case (state)
        ST_IDLE:  if (strobe.ackTake) state <= ST_SERVE;
        ST_SERVE: if (eosWr)          state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  p_ack_starts_service_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.inService) |-> $past(ackRead && anyCand));

  p_hold_until_eos_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inService && !eosWr) |=> strobe.inService);

  p_eos_ends_service_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inService && eosWr) |=> !strobe.inService);

endmodule

// File: rtl/intc_vectored.sv
module intc_vectored
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic               irqReqN
);

  ctlStrobe_t strobe;
  logic       anyCand;

  intc_control #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .anyCand(anyCand), .strobe(strobe), .irqReqN(irqReqN)
  );

  intc_datapath #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .irqIn(irqIn), .strobe(strobe),
    .anyCand(anyCand), .rdData(regRdData)
  );

endmodule

// File: tb/intc_vectored_tb.sv
module intc_vectored_tb;

  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic [N-1:0] irqIn = '0;
  logic        irqReqN;

  int nTests = 0, nFail = 0;
  int prioOf [N];

  always #4 clk = ~clk;

  intc_vectored u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqIn(irqIn), .irqReqN(irqReqN)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    regWrEn = 1'b1; regAddr = 12'(addr); regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    regRdEn = 1'b1; regAddr = 12'(addr);
    #1 data = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 req", 32'(irqReqN), 32'd1);
    rd('h110, d); chk("R1 enables", d, 32'h0);
    for (int n = 0; n < N; n++) begin rd(n * 4, d); chk("R1 ctrl", d, 32'h40); end

    // R2 control word fields
    wr(5 * 4, 32'hFFFF_FFC5); rd(5 * 4, d); chk("R2 fields", d, 32'hC5);
    wr(5 * 4, 32'h40);        rd(5 * 4, d); chk("R2 restore", d, 32'h40);

    // R3 write-one enable commands
    wr('h114, 32'hF0); rd('h110, d); chk("R3 unmask", d, 32'hF0);
    wr('h114, 32'h0F); rd('h110, d); chk("R3 unmask accum", d, 32'hFF);
    wr('h118, 32'h30); rd('h110, d); chk("R3 mask", d, 32'hCF);
    wr('h118, 32'h00); rd('h110, d); chk("R3 zero no effect", d, 32'hCF);
    wr('h118, 32'hFFFF_FFFF); rd('h110, d); chk("R3 mask all", d, 32'h0);

    // R11 / R10 masked pending input and status words
    irqIn = 32'h4; @(negedge clk);
    chk("R11 masked quiet", 32'(irqReqN), 32'd1);
    rd('h100, d); chk("R10 raw", d, 32'h4);
    rd('h104, d); chk("R10 pending", d, 32'h4);
    rd('h108, d); chk("R10 status masked", d, 32'h0);
    wr('h114, 32'h4);
    chk("R11 unmasked requests", 32'(irqReqN), 32'd0);
    rd('h108, d); chk("R10 status", d, 32'h4);
    rd('h10C, d); chk("R7 vector src2", d, 32'd8);
    irqIn = '0; wr('h124, 0);
    wr('h114, 32'hFFFF_FFFF);

    // R7 sweep over every input
    for (int n = 0; n < N; n++) begin
      irqIn = N'(1) << n; #1;
      chk("R7 request", 32'(irqReqN), 32'd0);
      rd('h10C, d); chk("R7 vector", d, 32'(n * 4));
      chk("R7 released", 32'(irqReqN), 32'd1);
      rd('h10C, d); chk("R7 reread", d, 32'(n * 4));
      chk("R7 still released", 32'(irqReqN), 32'd1);
      irqIn = '0; wr('h124, 0);
      chk("R8 idle after eos", 32'(irqReqN), 32'd1);
    end

    // R8 re-request after eos while level still active
    irqIn = 32'h80; #1;
    rd('h10C, d); chk("R8 vector", d, 32'd28);
    wr('h124, 0); chk("R8 re-request", 32'(irqReqN), 32'd0);
    rd('h10C, d); irqIn = '0; wr('h124, 0);
    chk("R8 final idle", 32'(irqReqN), 32'd1);

    // R4 low level
    wr(3 * 4, 32'h03); irqIn = 32'h8; @(negedge clk);
    chk("R4 low inactive", 32'(irqReqN), 32'd1);
    irqIn = 32'h0; #1;
    chk("R4 low active", 32'(irqReqN), 32'd0);
    rd('h10C, d); chk("R4 vector", d, 32'd12);
    irqIn = 32'h8; wr('h124, 0);
    chk("R4 low released", 32'(irqReqN), 32'd1);
    wr(3 * 4, 32'h40); irqIn = '0; @(negedge clk);

    // R5 rising edge
    wr(9 * 4, 32'hC0);
    irqIn = 32'h200; @(negedge clk); irqIn = '0; @(negedge clk);
    chk("R5 rise latched", 32'(irqReqN), 32'd0);
    rd('h104, d); chk("R5 pending", d, 32'h200);
    rd('h10C, d); chk("R5 vector", d, 32'd36);
    wr('h124, 0);
    chk("R5 cleared by ack", 32'(irqReqN), 32'd1);
    rd('h104, d); chk("R5 pending clear", d, 32'h0);

    // R5 falling edge
    wr(10 * 4, 32'h80);
    irqIn = 32'h400; @(negedge clk); @(negedge clk);
    chk("R5 no fall yet", 32'(irqReqN), 32'd1);
    irqIn = '0; @(negedge clk);
    chk("R5 fall latched", 32'(irqReqN), 32'd0);
    rd('h10C, d); chk("R5 fall vector", d, 32'd40);
    wr('h124, 0); chk("R5 fall cleared", 32'(irqReqN), 32'd1);
    wr(9 * 4, 32'h40); wr(10 * 4, 32'h40);

    // R9 software force and unforce
    wr('h11C, 32'h1000); chk("R9 forced", 32'(irqReqN), 32'd0);
    rd('h104, d); chk("R9 pending", d, 32'h1000);
    wr('h120, 32'h1000); chk("R9 unforced", 32'(irqReqN), 32'd1);
    wr('h11C, 32'h1000);
    rd('h10C, d); chk("R9 vector", d, 32'd48);
    wr('h124, 0); chk("R9 ack clears", 32'(irqReqN), 32'd1);

    // R6 priority sweep with ties
    for (int n = 0; n < N; n++) begin
      prioOf[n] = (n * 3 + 1) % 8;
      wr(n * 4, 32'h40 | 32'(prioOf[n]));
    end
    for (int k = 0; k < 48; k++) begin
      logic [31:0] pat;
      int best, bp;
      pat = (32'(k) * 32'h9E37_79B9) ^ (32'(k) << 7);
      if (k % 6 == 0) pat = 32'h0101_0101 << (k % 8);
      best = -1; bp = -1;
      for (int n = 0; n < N; n++)
        if (pat[n] && prioOf[n] > bp) begin bp = prioOf[n]; best = n; end
      irqIn = pat; #1;
      if (best < 0) chk("R6 none", 32'(irqReqN), 32'd1);
      else begin
        chk("R6 request", 32'(irqReqN), 32'd0);
        rd('h10C, d); chk("R6 winner", d, 32'(best * 4));
        irqIn = '0; wr('h124, 0);
      end
      @(negedge clk);
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule